// File: doc/BRIEF.md
# SCSI Initiator Command Dispatcher

This block sits behind the command register of a register-mapped SCSI initiator controller. The host writes bytes through a small register port, and writing the command register starts one of a handful of controller operations. The supported operations are a software reset, an attention request, a disconnect, a plain selection, and a selection that carries on into a transfer.

The SCSI bus itself is not modelled. For each of the eight target IDs, an input vector says whether a target is present and whether it is busy. When a select-and-transfer succeeds, two further inputs say where the target goes next and, if it goes straight to status, what status byte it returns. The block updates its status registers and its connection state. On a selection with attention it also emits the identify message byte.

While a command is in progress, the command register refuses new commands. This lets the host poll the auxiliary status before it issues the next operation.

Top module: `scsi_cmd_dispatch`

## Requirements
- R1: After `rst_n` is released, every readable register reads 0x00, `link_active` is 0 and `ident_valid` is 0. Addresses are: own ID 0x00, target LUN 0x0F, transfer count bytes 0x12/0x13/0x14, destination ID 0x15, SCSI status 0x17, command 0x18, auxiliary status 0x1F. All other addresses read 0x00.
- R2: A write to the command register is stored and reads back on the next cycle. The command takes effect on the clock edge after the edge that captured the write. SCSI status (0x17) and auxiliary status (0x1F) cannot be written by the host.
- R3: While auxiliary status bit 4 (command in progress) is set, a command write is ignored. The command register, the status registers and `link_active` keep their values.
- R4: Command 0x00 clears addresses 0x01 through 0x1A and drops any link. It keeps the own-ID register and the auxiliary status. It then loads SCSI status with 0x01 if own-ID bit 3 (advanced features) is set, and with 0x00 otherwise.
- R5: Command 0x04 drops the link. Command 0x02 leaves every register unchanged apart from the command readback.
- R6: Commands 0x06 and 0x07 set `sel_target` to destination-ID bits 2:0 and clear the transfer count. They load SCSI status with 0x42 and set auxiliary status to exactly 0x80 (interrupt, bit 7).
- R7: Commands 0x08 and 0x09 succeed only when all of these hold: no device is busy on the block's side, the target ID is below `MAX_DEV`, the target's `tgt_present` bit is 1, and its `tgt_busy` bit is 0.
- R8: A successful 0x08 pulses `ident_valid` for one cycle, with `ident_byte` equal to the target LUN register OR 0x80. Command 0x09 never pulses it.
- R9: A failed 0x08 or 0x09 clears the transfer count, loads SCSI status with 0x42 and sets auxiliary status to 0x80.
- R10: On success with `tgt_phase`=0 (straight to status), the block writes `tgt_status` into the target LUN register and loads SCSI status with 0x16. No link remains and auxiliary status is unchanged.
- R11: On success with `tgt_phase`=1 (executing), auxiliary status becomes 0x30 (busy bit 5, in-progress bit 4). With `tgt_phase`=2 or 3 (data), it becomes 0x31 (adding data-buffer-ready, bit 0). In both cases `link_active` goes to 1 and `link_id` holds the target ID. The transfer count is kept.
- R12: Any other command code, 0x18 included, changes nothing except the command readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| tgt_present | input | 2**ID_W | Target answers selection, one bit per ID |
| tgt_busy | input | 2**ID_W | Target refuses selection, one bit per ID |
| tgt_phase | input | 2 | Phase after command: 0 status, 1 executing, 2/3 data |
| tgt_status | input | 8 | Status byte returned on a straight-to-status completion |
| sel_target | output | ID_W | Target ID taken by the last selection |
| link_active | output | 1 | A target connection is held |
| link_id | output | ID_W | ID of the connected target |
| ident_valid | output | 1 | Identify message strobe |
| ident_byte | output | 8 | Identify message byte |

## Verification
A command write is captured at one clock edge and executed at the next. Status, auxiliary status, link and `sel_target` are therefore due two edges after the strobe goes high. The bench raises the strobe at a falling edge, drops it one falling edge later, and samples at the falling edge after that. `ident_valid` is high only between the execute edge and the following edge, so it is read at that same sampling point. Register reads are combinational and are sampled one time unit after the address changes. Rejection under command-in-progress is checked at the same point.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

   localparam int A_OWNID  = 'h00;
   localparam int A_LUN    = 'h0F;
   localparam int A_TC0    = 'h12;
   localparam int A_TC1    = 'h13;
   localparam int A_TC2    = 'h14;
   localparam int A_DEST   = 'h15;
   localparam int A_STATUS = 'h17;
   localparam int A_CMD    = 'h18;
   localparam int A_AUX    = 'h1F;

   localparam logic [7:0] ST_RESET      = 8'h00;
   localparam logic [7:0] ST_RESET_ADV  = 8'h01;
   localparam logic [7:0] ST_SEL_TMO    = 8'h42;
   localparam logic [7:0] ST_XFER_DONE  = 8'h16;

   localparam int AUX_INT = 7;
   localparam int AUX_BSY = 5;
   localparam int AUX_CIP = 4;
   localparam int AUX_DBR = 0;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_RESET,
      OP_ATN,
      OP_DISC,
      OP_SEL,
      OP_SELX
   } op_e;

   typedef enum logic [1:0] {
      PH_STATUS = 2'd0,
      PH_EXEC   = 2'd1,
      PH_DATA   = 2'd2,
      PH_DATA2  = 2'd3
   } phase_e;

endpackage

// File: rtl/scd_decode.sv
module scd_decode
   import scsi_cmd_pkg::*;
(
   input  logic [7:0] code,
   output op_e        op,
   output logic       with_atn
);
   always_comb begin
      op       = OP_NONE;
      with_atn = 1'b0;
      case (code)
         8'h00: op = OP_RESET;
         8'h02: op = OP_ATN;
         8'h04: op = OP_DISC;
         8'h06: begin op = OP_SEL;  with_atn = 1'b1; end
         8'h07: op = OP_SEL;
         8'h08: begin op = OP_SELX; with_atn = 1'b1; end
         8'h09: op = OP_SELX;
         default: op = OP_NONE;
      endcase
   end
endmodule

// File: rtl/scd_select_eval.sv
module scd_select_eval #(
   parameter int ID_W    = 3,
   parameter int MAX_DEV = 7
) (
   input  logic [ID_W-1:0]      id,
   input  logic                 dev_busy,
   input  logic [(1<<ID_W)-1:0] present,
   input  logic [(1<<ID_W)-1:0] busy,
   output logic                 ok
);
   localparam int NTGT = 1 << ID_W;

   logic in_range;
   if (MAX_DEV >= NTGT) begin : g_all_ids
      assign in_range = 1'b1;
   end else begin : g_limited
      assign in_range = (int'(id) < MAX_DEV);
   end

   assign ok = !dev_busy && in_range && present[id] && !busy[id];
endmodule

// File: rtl/scsi_cmd_dispatch.sv
module scsi_cmd_dispatch
   import scsi_cmd_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int ID_W         = 3,
   parameter int MAX_DEV      = 7,
   parameter bit ADV_RESET_EN = 1'b1,
   parameter int ADV_BIT      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [7:0]           host_wdata,
   input  logic                 host_we,
   output logic [7:0]           host_rdata,
   input  logic [(1<<ID_W)-1:0] tgt_present,
   input  logic [(1<<ID_W)-1:0] tgt_busy,
   input  logic [1:0]           tgt_phase,
   input  logic [7:0]           tgt_status,
   output logic [ID_W-1:0]      sel_target,
   output logic                 link_active,
   output logic [ID_W-1:0]      link_id,
   output logic                 ident_valid,
   output logic [7:0]           ident_byte
);
   localparam int NTGT = 1 << ID_W;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("scsi_cmd_dispatch: ADDR_W must be at least 5");
   end
   if (ID_W < 1 || ID_W > 3) begin : g_bad_id
      $error("scsi_cmd_dispatch: ID_W must be 1 to 3");
   end
   if (MAX_DEV < 1 || MAX_DEV > NTGT) begin : g_bad_dev
      $error("scsi_cmd_dispatch: MAX_DEV out of range");
   end
   if (ADV_BIT < 0 || ADV_BIT > 7) begin : g_bad_adv
      $error("scsi_cmd_dispatch: ADV_BIT out of range");
   end

   logic [7:0]      own_q, lun_q, dest_q, status_q, cmd_q, aux_q;
   logic [7:0]      tc_q [3];
   logic            pend_q, dev_busy_q, link_q;
   logic [ID_W-1:0] link_id_q, sel_q;
   logic            ident_v_q;
   logic [7:0]      ident_b_q;

   op_e             op;
   logic            op_atn;
   logic            sel_ok;
   logic [7:0]      rst_code;
   logic [ID_W-1:0] dest_id;
   logic            wr_cmd, accept;

   assign dest_id = dest_q[ID_W-1:0];
   assign wr_cmd  = host_we && (host_addr == ADDR_W'(A_CMD));
   assign accept  = wr_cmd && !aux_q[AUX_CIP];

   scd_decode u_dec (
      .code     (cmd_q),
      .op       (op),
      .with_atn (op_atn)
   );

   scd_select_eval #(.ID_W(ID_W), .MAX_DEV(MAX_DEV)) u_sel (
      .id       (dest_id),
      .dev_busy (dev_busy_q),
      .present  (tgt_present),
      .busy     (tgt_busy),
      .ok       (sel_ok)
   );

   if (ADV_RESET_EN) begin : g_adv_reset
      assign rst_code = own_q[ADV_BIT] ? ST_RESET_ADV : ST_RESET;
   end else begin : g_plain_reset
      assign rst_code = ST_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q      <= '0;
         lun_q      <= '0;
         dest_q     <= '0;
         status_q   <= '0;
         cmd_q      <= '0;
         aux_q      <= '0;
         for (int i = 0; i < 3; i++) tc_q[i] <= '0;
         pend_q     <= 1'b0;
         dev_busy_q <= 1'b0;
         link_q     <= 1'b0;
         link_id_q  <= '0;
         sel_q      <= '0;
         ident_v_q  <= 1'b0;
         ident_b_q  <= '0;
      end else begin
         ident_v_q <= 1'b0;
         pend_q    <= accept;
         if (accept) cmd_q <= host_wdata;
         if (host_we) begin
            if (host_addr == ADDR_W'(A_OWNID)) own_q   <= host_wdata;
            if (host_addr == ADDR_W'(A_LUN))   lun_q   <= host_wdata;
            if (host_addr == ADDR_W'(A_DEST))  dest_q  <= host_wdata;
            if (host_addr == ADDR_W'(A_TC0))   tc_q[0] <= host_wdata;
            if (host_addr == ADDR_W'(A_TC1))   tc_q[1] <= host_wdata;
            if (host_addr == ADDR_W'(A_TC2))   tc_q[2] <= host_wdata;
         end
         if (pend_q) begin
            case (op)
               OP_RESET: begin
                  lun_q  <= '0;
                  dest_q <= '0;
                  for (int i = 0; i < 3; i++) tc_q[i] <= '0;
                  if (!accept) cmd_q <= '0;
                  status_q   <= rst_code;
                  link_q     <= 1'b0;
                  dev_busy_q <= 1'b0;
               end
               OP_DISC: begin
                  link_q     <= 1'b0;
                  dev_busy_q <= 1'b0;
               end
               OP_SEL: begin
                  sel_q    <= dest_id;
                  for (int i = 0; i < 3; i++) tc_q[i] <= '0;
                  status_q <= ST_SEL_TMO;
                  aux_q    <= 8'h1 << AUX_INT;
               end
               OP_SELX: begin
                  sel_q <= dest_id;
                  if (sel_ok) begin
                     if (op_atn) begin
                        ident_v_q <= 1'b1;
                        ident_b_q <= lun_q | 8'h80;
                     end
                     case (phase_e'(tgt_phase))
                        PH_STATUS: begin
                           lun_q      <= tgt_status;
                           status_q   <= ST_XFER_DONE;
                           link_q     <= 1'b0;
                           dev_busy_q <= 1'b0;
                        end
                        PH_EXEC: begin
                           aux_q      <= (8'h1 << AUX_CIP) | (8'h1 << AUX_BSY);
                           dev_busy_q <= 1'b1;
                           link_q     <= 1'b1;
                           link_id_q  <= dest_id;
                        end
                        default: begin
                           aux_q      <= (8'h1 << AUX_CIP) | (8'h1 << AUX_BSY)
                                         | (8'h1 << AUX_DBR);
                           dev_busy_q <= 1'b0;
                           link_q     <= 1'b1;
                           link_id_q  <= dest_id;
                        end
                     endcase
                  end else begin
                     for (int i = 0; i < 3; i++) tc_q[i] <= '0;
                     status_q <= ST_SEL_TMO;
                     aux_q    <= 8'h1 << AUX_INT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if      (host_addr == ADDR_W'(A_OWNID))  host_rdata = own_q;
      else if (host_addr == ADDR_W'(A_LUN))    host_rdata = lun_q;
      else if (host_addr == ADDR_W'(A_TC0))    host_rdata = tc_q[0];
      else if (host_addr == ADDR_W'(A_TC1))    host_rdata = tc_q[1];
      else if (host_addr == ADDR_W'(A_TC2))    host_rdata = tc_q[2];
      else if (host_addr == ADDR_W'(A_DEST))   host_rdata = dest_q;
      else if (host_addr == ADDR_W'(A_STATUS)) host_rdata = status_q;
      else if (host_addr == ADDR_W'(A_CMD))    host_rdata = cmd_q;
      else if (host_addr == ADDR_W'(A_AUX))    host_rdata = aux_q;
   end

   assign sel_target  = sel_q;
   assign link_active = link_q;
   assign link_id     = link_id_q;
   assign ident_valid = ident_v_q;
   assign ident_byte  = ident_b_q;
endmodule

// File: rtl/scd_checker.sv
module scd_checker
   import scsi_cmd_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic [7:0]        aux_q,
   input logic [7:0]        cmd_q,
   input logic [7:0]        status_q,
   input logic              link_q,
   input logic              ident_valid,
   input logic [7:0]        ident_byte
);
   // R3: a command write under command-in-progress leaves the command register alone
   a_r3_cip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_q[AUX_CIP] && host_we && host_addr == ADDR_W'(A_CMD)) |=> $stable(cmd_q));

   // R8: the identify byte always carries bit 7
   a_r8_ident_msb: assert property (@(posedge clk) disable iff (!rst_n)
      ident_valid |-> ident_byte[7]);

   // R9: a fresh selection-timeout status comes with interrupt-only auxiliary status
   a_r9_timeout_aux: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(status_q) && status_q == ST_SEL_TMO) |-> aux_q == 8'h80);

   // R10: a fresh transfer-complete status leaves no link
   a_r10_done_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(status_q) && status_q == ST_XFER_DONE) |-> !link_q);

   // R11: a held link always shows command in progress
   a_r11_link_cip: assert property (@(posedge clk) disable iff (!rst_n)
      link_q |-> aux_q[AUX_CIP]);
endmodule

bind scsi_cmd_dispatch scd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .aux_q       (aux_q),
   .cmd_q       (cmd_q),
   .status_q    (status_q),
   .link_q      (link_q),
   .ident_valid (ident_valid),
   .ident_byte  (ident_byte)
);

// File: tb/sim_scsi_cmd_dispatch.sv
`timescale 1ns/1ps
module sim_scsi_cmd_dispatch;
   localparam int MAXD = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       host_we = 1'b0;
   logic [7:0] host_rdata;
   logic [7:0] tgt_present = '0;
   logic [7:0] tgt_busy = '0;
   logic [1:0] tgt_phase = '0;
   logic [7:0] tgt_status = '0;
   logic [2:0] sel_target;
   logic       link_active;
   logic [2:0] link_id;
   logic       ident_valid;
   logic [7:0] ident_byte;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scsi_cmd_dispatch #(.MAX_DEV(MAXD)) u0 (
      .clk, .rst_n, .host_addr, .host_wdata, .host_we, .host_rdata,
      .tgt_present, .tgt_busy, .tgt_phase, .tgt_status,
      .sel_target, .link_active, .link_id, .ident_valid, .ident_byte
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // command write, then wait for the execute edge; caller samples next
   task automatic cmd(input logic [7:0] c);
      wr(5'h18, c);
      @(negedge clk);
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1500000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      pulse_reset();

      // R1 reset state over the whole address space
      for (int a = 0; a < 32; a++) begin
         rd(5'(a), v);
         chk("R1", v, 0);
      end
      chk("R1 link", link_active, 0);
      chk("R1 ident", ident_valid, 0);

      // R2 readback, read-only status registers
      wr(5'h17, 8'h55); wr(5'h1F, 8'h55);
      @(negedge clk);
      rd(5'h17, v); chk("R2 status ro", v, 0);
      rd(5'h1F, v); chk("R2 aux ro", v, 0);
      wr(5'h18, 8'h02);
      rd(5'h18, v); chk("R2 readback", v, 8'h02);

      // R4 reset command, advanced and plain
      for (int adv = 0; adv < 2; adv++) begin
         wr(5'h00, adv ? 8'h08 : 8'h07);
         wr(5'h15, 8'h0D); wr(5'h0F, 8'h03);
         wr(5'h12, 8'hAA); wr(5'h13, 8'hBB); wr(5'h14, 8'hCC);
         cmd(8'h00);
         for (int a = 1; a <= 'h1A; a++) begin
            rd(5'(a), v);
            if (a == 'h17) chk("R4 status", v, adv ? 1 : 0);
            else chk("R4 cleared", v, 0);
         end
         rd(5'h00, v); chk("R4 own kept", v, adv ? 8'h08 : 8'h07);
      end

      // R5 assert ATN and disconnect leave registers
      wr(5'h15, 8'h0B); wr(5'h0F, 8'h21); wr(5'h12, 8'h5A);
      cmd(8'h02);
      rd(5'h15, v); chk("R5 atn dest", v, 8'h0B);
      rd(5'h0F, v); chk("R5 atn lun", v, 8'h21);
      rd(5'h12, v); chk("R5 atn tc", v, 8'h5A);
      rd(5'h17, v); chk("R5 atn status", v, 1);
      rd(5'h1F, v); chk("R5 atn aux", v, 0);
      cmd(8'h04);
      chk("R5 disc link", link_active, 0);
      rd(5'h12, v); chk("R5 disc tc", v, 8'h5A);

      // R6 plain select, both codes
      for (int c = 6; c < 8; c++) begin
         pulse_reset();
         wr(5'h15, 8'hF8 | 8'(c - 1)); wr(5'h13, 8'h77);
         cmd(8'(c));
         chk("R6 target", sel_target, c - 1);
         rd(5'h13, v); chk("R6 tc", v, 0);
         rd(5'h17, v); chk("R6 status", v, 8'h42);
         rd(5'h1F, v); chk("R6 aux", v, 8'h80);
      end

      // R7-R11 sweep of select-and-transfer
      for (int id = 0; id < 8; id++)
      for (int pr = 0; pr < 2; pr++)
      for (int bz = 0; bz < 2; bz++)
      for (int ph = 0; ph < 3; ph++)
      for (int at = 0; at < 2; at++) begin
         bit ok;
         logic [7:0] lunv;
         bit idv;
         logic [7:0] idb;
         ok = pr && !bz && id < MAXD;
         lunv = 8'h10 + 8'(id);
         pulse_reset();
         tgt_present = pr ? (8'h1 << id) : (~(8'h1 << id));
         tgt_busy = bz ? (8'h1 << id) : 8'h00;
         tgt_phase = 2'(ph);
         tgt_status = 8'hC0 | 8'(id);
         wr(5'h15, 8'(id)); wr(5'h0F, lunv); wr(5'h12, 8'hAA);
         cmd(at ? 8'h08 : 8'h09);
         idv = ident_valid; idb = ident_byte;
         chk("R8 ident_valid", idv, ok && at);
         if (ok && at) chk("R8 ident_byte", idb, lunv | 8'h80);
         chk("R7 sel_target", sel_target, id);
         rd(5'h17, v);
         chk("R7 status", v, !ok ? 8'h42 : (ph == 0 ? 8'h16 : 8'h00));
         rd(5'h1F, v);
         chk("R11 aux", v, !ok ? 8'h80 : (ph == 0 ? 8'h00 : (ph == 1 ? 8'h30 : 8'h31)));
         rd(5'h12, v); chk("R9 tc", v, ok ? 8'hAA : 8'h00);
         rd(5'h0F, v); chk("R10 lun", v, (ok && ph == 0) ? (8'hC0 | 8'(id)) : lunv);
         chk("R11 link", link_active, ok && ph != 0);
         if (ok && ph != 0) begin
            chk("R11 link_id", link_id, id);
            // R3 command-in-progress rejects a reset command
            cmd(8'h00);
            rd(5'h18, v); chk("R3 cmd kept", v, at ? 8'h08 : 8'h09);
            rd(5'h1F, v); chk("R3 aux kept", v, ph == 1 ? 8'h30 : 8'h31);
            rd(5'h0F, v); chk("R3 lun kept", v, lunv);
            chk("R3 link kept", link_active, 1);
         end
      end

      // R12 every unsupported code
      pulse_reset();
      wr(5'h00, 8'h08);
      cmd(8'h00);
      wr(5'h15, 8'h03); wr(5'h12, 8'h99);
      for (int c = 0; c < 256; c++) begin
         if (c == 0 || c == 2 || c == 4 || (c >= 6 && c <= 9)) continue;
         cmd(8'(c));
         rd(5'h18, v); chk("R12 readback", v, c);
         rd(5'h17, v); chk("R12 status", v, 8'h01);
         rd(5'h1F, v); chk("R12 aux", v, 0);
         rd(5'h12, v); chk("R12 tc", v, 8'h99);
         chk("R12 link", link_active, 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule